// File: doc/BRIEF.md
# Flash read buffer with hazard eviction and in-order return

This block is a small fully associative cache of read words that sits in front of a flash read port. Two requesters share it: a host port that reads directly and a controller port. Each read is looked up against a handful of buffer entries. A hit returns the stored word one cycle after acceptance. A miss issues a read to the backing memory, which answers one cycle later. The word then goes through a fixed-latency stage, short for plain regions and long for scrambled regions, and is copied into a buffer entry.

The controller also issues program and erase commands. These commands snoop the buffer and invalidate every entry whose contents they make stale, so a read that follows them sees the new memory contents. Responses leave on one shared port in the order the reads were accepted, even when a later fast miss finishes before an earlier slow one. Each entry shows its address, a valid flag and a hazard flag. The hazard flag marks an entry that was evicted by a command.

Top module: `flash_rdbuf`

## Requirements
- R1: After reset no entry is valid, no hazard flag is set, `rsp_vld` and `mem_rd_en` are low, and both read ports are ready.
- R2: A read whose word address is held in a valid entry produces its response in the cycle after acceptance and issues no backing-memory read.
- R3: A miss raises `mem_rd_en` with the address in its acceptance cycle. It responds 1+FAST_LAT cycles later (2 by default) when address bit SCR_BIT (bit 6) is 0, and 1+SLOW_LAT cycles later (5 by default) when that bit is 1. The response carries the memory word as it was at acceptance.
- R4: A miss's data is stored in the lowest-numbered invalid entry. If every entry is valid, a round-robin pointer that starts at entry 0 after reset picks the entry. A word already held is never stored twice.
- R5: Command kind 1 (program) invalidates the entry whose address equals `ctl_op_addr` and sets that entry's hazard flag. A later read of that word misses and returns the programmed data. Refilling the entry clears its hazard flag.
- R6: Command kind 2 (page erase) invalidates every entry whose address bits [7:3] equal those of `ctl_op_addr`. Other entries are unchanged.
- R7: Command kind 3 (bank erase) invalidates every entry whose address bit 7 equals that of `ctl_op_addr`.
- R8: Command kind 0 changes no entry and no hazard flag.
- R9: Responses come out in acceptance order. `rsp_src` is 0 for a host read and 1 for a controller read.
- R10: When both ports request in the same cycle, the host is accepted first and `ctl_rd_rdy` stays low while `hst_rd_vld` is high.
- R11: At most NTAG (4) reads are outstanding. Both ready outputs are low while four are pending.
- R12: No read is accepted and no memory read is issued in a cycle where `ctl_op_vld` is high.
- R13: `buf_addr[i*AW +: AW]`, `buf_vld[i]` and `buf_haz[i]` show the address, valid flag and hazard flag of entry i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hst_rd_vld | input | 1 | Host read request |
| hst_rd_addr | input | AW | Host word address |
| hst_rd_rdy | output | 1 | Host request accepted this cycle |
| ctl_rd_vld | input | 1 | Controller read request |
| ctl_rd_addr | input | AW | Controller word address |
| ctl_rd_rdy | output | 1 | Controller request accepted this cycle |
| ctl_op_vld | input | 1 | Program or erase command strobe |
| ctl_op_kind | input | 2 | 0 none, 1 program, 2 page erase, 3 bank erase |
| ctl_op_addr | input | AW | Command target word address |
| mem_rd_en | output | 1 | Backing memory read strobe |
| mem_rd_addr | output | AW | Backing memory read address |
| mem_rd_data | input | DW | Memory word, valid one cycle after the strobe |
| rsp_vld | output | 1 | Response valid |
| rsp_src | output | 1 | Response owner, 0 host, 1 controller |
| rsp_data | output | DW | Response word |
| buf_vld | output | NBUF | Entry valid flags |
| buf_haz | output | NBUF | Entry evicted-by-command flags |
| buf_addr | output | NBUF*AW | Entry addresses, entry i at bits i*AW upward |

## Verification
If an eviction is missed, the stale entry shows up at the ports on the next read of that word: the read responds after one cycle instead of the miss delay, carries pre-command data, and the valid and hazard flags stay wrong on the status port from the cycle after the command. A fault in the tag ring or the holding registers shows up as a response whose owner or data does not match the acceptance order. A wrong outstanding count shows up as the ready outputs stalling for the wrong number of cycles. A replacement fault shows up on `buf_addr` as soon as the fill lands, one cycle after the miss.

// File: rtl/flash_rdbuf_pkg.sv
package flash_rdbuf_pkg;

   typedef enum logic [1:0] {
      OPK_NONE       = 2'd0,
      OPK_PROG       = 2'd1,
      OPK_ERASE_PAGE = 2'd2,
      OPK_ERASE_BANK = 2'd3
   } opk_e;

   typedef enum logic {
      SRC_HOST = 1'b0,
      SRC_CTRL = 1'b1
   } src_e;

endpackage

// File: rtl/flash_rdbuf_entries.sv
module flash_rdbuf_entries
   import flash_rdbuf_pkg::*;
#(
   parameter int AW   = 8,
   parameter int DW   = 16,
   parameter int NBUF = 4,
   parameter int PG_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     look_addr,
   output logic              look_hit,
   output logic [DW-1:0]     look_data,
   input  logic              fill_vld,
   input  logic [AW-1:0]     fill_addr,
   input  logic [DW-1:0]     fill_data,
   input  logic              op_vld,
   input  opk_e              op_kind,
   input  logic [AW-1:0]     op_addr,
   output logic [NBUF-1:0]   st_vld,
   output logic [NBUF-1:0]   st_haz,
   output logic [NBUF*AW-1:0] st_addr
);
   localparam int IW = (NBUF > 1) ? $clog2(NBUF) : 1;

   function automatic logic op_hits(opk_e k, logic [AW-1:0] ea, logic [AW-1:0] oa);
      case (k)
         OPK_PROG:       return ea == oa;
         OPK_ERASE_PAGE: return ea[AW-1:PG_W] == oa[AW-1:PG_W];
         OPK_ERASE_BANK: return ea[AW-1] == oa[AW-1];
         default:        return 1'b0;
      endcase
   endfunction

   logic [NBUF-1:0] vld_q, haz_q, hitv, dupv, evv;
   logic [AW-1:0]   addr_q [NBUF];
   logic [DW-1:0]   data_q [NBUF];
   logic [IW-1:0]   rr_q, rr_nxt, free_idx, victim;
   logic            free_any, fill_go;

   for (genvar i = 0; i < NBUF; i++) begin : g_ent
      assign hitv[i] = vld_q[i] && (addr_q[i] == look_addr);
      assign dupv[i] = vld_q[i] && (addr_q[i] == fill_addr);
      assign evv[i]  = op_vld && vld_q[i] && op_hits(op_kind, addr_q[i], op_addr);
      assign st_addr[i*AW +: AW] = addr_q[i];

      AST_PROG_GONE: assert property (@(posedge clk) disable iff (!rst_n)
         (op_vld && op_kind == OPK_PROG) |=> !(vld_q[i] && addr_q[i] == $past(op_addr)))
         else $error("programmed word still buffered"); // R5
      AST_PAGE_GONE: assert property (@(posedge clk) disable iff (!rst_n)
         (op_vld && op_kind == OPK_ERASE_PAGE) |=>
            !(vld_q[i] && addr_q[i][AW-1:PG_W] == $past(op_addr[AW-1:PG_W])))
         else $error("erased page still buffered"); // R6
      AST_HAZ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
         haz_q[i] |-> !vld_q[i])
         else $error("hazard flag on a valid entry"); // R13
   end

   if ((NBUF & (NBUF - 1)) == 0) begin : g_rr_pow2
      assign rr_nxt = rr_q + 1'b1;
   end else begin : g_rr_wrap
      assign rr_nxt = (rr_q == IW'(NBUF - 1)) ? '0 : rr_q + 1'b1;
   end

   always_comb begin
      look_data = '0;
      free_any  = 1'b0;
      free_idx  = '0;
      for (int i = 0; i < NBUF; i++) begin
         if (hitv[i]) look_data = look_data | data_q[i];
      end
      for (int i = NBUF - 1; i >= 0; i--) begin
         if (!vld_q[i]) begin
            free_any = 1'b1;
            free_idx = IW'(i);
         end
      end
   end

   assign look_hit = |hitv;
   assign victim   = free_any ? free_idx : rr_q;
   assign fill_go  = fill_vld && !(|dupv) && !(op_vld && op_hits(op_kind, fill_addr, op_addr));
   assign st_vld   = vld_q;
   assign st_haz   = haz_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         haz_q <= '0;
         rr_q  <= '0;
         for (int i = 0; i < NBUF; i++) begin
            addr_q[i] <= '0;
            data_q[i] <= '0;
         end
      end else begin
         vld_q <= vld_q & ~evv;
         haz_q <= haz_q | evv;
         if (fill_go) begin
            vld_q[victim]  <= 1'b1;
            haz_q[victim]  <= 1'b0;
            addr_q[victim] <= fill_addr;
            data_q[victim] <= fill_data;
            if (!free_any) rr_q <= rr_nxt;
         end
      end
   end

   AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hitv))
      else $error("word held in two entries"); // R4

endmodule

// File: rtl/flash_rdbuf_order.sv
module flash_rdbuf_order
   import flash_rdbuf_pkg::*;
#(
   parameter int AW       = 8,
   parameter int DW       = 16,
   parameter int NTAG     = 4,
   parameter int FAST_LAT = 1,
   parameter int SLOW_LAT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc,
   input  src_e          acc_src,
   input  logic          acc_hit,
   input  logic          acc_slow,
   input  logic [AW-1:0] acc_addr,
   input  logic [DW-1:0] acc_data,
   input  logic [DW-1:0] mem_data,
   output logic          full,
   output logic          arr_vld,
   output logic [AW-1:0] arr_addr,
   output logic          rsp_vld,
   output src_e          rsp_src,
   output logic [DW-1:0] rsp_data
);
   localparam int TW = $clog2(NTAG);
   localparam int LW = $clog2(SLOW_LAT + 1);

   logic [NTAG-1:0] busy_q, got_q, src_q;
   logic [LW-1:0]   lat_q [NTAG];
   logic [DW-1:0]   data_q [NTAG];
   logic [TW-1:0]   wptr_q, rptr_q, pend_tag_q;
   logic [TW:0]     cnt_q;
   logic            pend_vld_q, head_done;
   logic [AW-1:0]   pend_addr_q;

   assign head_done = busy_q[rptr_q] && got_q[rptr_q] && (lat_q[rptr_q] == '0);
   assign full      = (cnt_q == (TW+1)'(NTAG));
   assign arr_vld   = pend_vld_q;
   assign arr_addr  = pend_addr_q;
   assign rsp_vld   = head_done;
   assign rsp_src   = src_e'(src_q[rptr_q]);
   assign rsp_data  = data_q[rptr_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q      <= '0;
         got_q       <= '0;
         src_q       <= '0;
         wptr_q      <= '0;
         rptr_q      <= '0;
         cnt_q       <= '0;
         pend_vld_q  <= 1'b0;
         pend_tag_q  <= '0;
         pend_addr_q <= '0;
         for (int t = 0; t < NTAG; t++) begin
            lat_q[t]  <= '0;
            data_q[t] <= '0;
         end
      end else begin
         for (int t = 0; t < NTAG; t++) begin
            if (lat_q[t] != '0) lat_q[t] <= lat_q[t] - 1'b1;
         end
         pend_vld_q <= acc && !acc_hit;
         if (pend_vld_q) begin
            data_q[pend_tag_q] <= mem_data;
            got_q[pend_tag_q]  <= 1'b1;
         end
         if (acc) begin
            busy_q[wptr_q] <= 1'b1;
            src_q[wptr_q]  <= acc_src;
            if (acc_hit) begin
               got_q[wptr_q]  <= 1'b1;
               lat_q[wptr_q]  <= '0;
               data_q[wptr_q] <= acc_data;
            end else begin
               got_q[wptr_q] <= 1'b0;
               lat_q[wptr_q] <= acc_slow ? LW'(SLOW_LAT) : LW'(FAST_LAT);
               pend_tag_q    <= wptr_q;
               pend_addr_q   <= acc_addr;
            end
            wptr_q <= wptr_q + 1'b1;
         end
         if (head_done) begin
            busy_q[rptr_q] <= 1'b0;
            rptr_q         <= rptr_q + 1'b1;
         end
         case ({acc, head_done})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= (TW+1)'(NTAG))
      else $error("more reads outstanding than tags"); // R11
   AST_ARRIVE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      pend_vld_q |-> (busy_q[pend_tag_q] && !got_q[pend_tag_q]))
      else $error("memory word for a closed tag"); // R3
   AST_HEAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |-> busy_q[rptr_q])
      else $error("oldest tag lost"); // R9

endmodule

// File: rtl/flash_rdbuf.sv
module flash_rdbuf
   import flash_rdbuf_pkg::*;
#(
   parameter int AW       = 8,
   parameter int DW       = 16,
   parameter int NBUF     = 4,
   parameter int NTAG     = 4,
   parameter int PG_W     = 3,
   parameter int SCR_BIT  = 6,
   parameter int FAST_LAT = 1,
   parameter int SLOW_LAT = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hst_rd_vld,
   input  logic [AW-1:0]      hst_rd_addr,
   output logic               hst_rd_rdy,
   input  logic               ctl_rd_vld,
   input  logic [AW-1:0]      ctl_rd_addr,
   output logic               ctl_rd_rdy,
   input  logic               ctl_op_vld,
   input  logic [1:0]         ctl_op_kind,
   input  logic [AW-1:0]      ctl_op_addr,
   output logic               mem_rd_en,
   output logic [AW-1:0]      mem_rd_addr,
   input  logic [DW-1:0]      mem_rd_data,
   output logic               rsp_vld,
   output logic               rsp_src,
   output logic [DW-1:0]      rsp_data,
   output logic [NBUF-1:0]    buf_vld,
   output logic [NBUF-1:0]    buf_haz,
   output logic [NBUF*AW-1:0] buf_addr
);
   if (NTAG < 2 || (NTAG & (NTAG - 1)) != 0) begin : g_bad_ntag
      $error("NTAG must be a power of two of at least 2");
   end
   if (NBUF < 1) begin : g_bad_nbuf
      $error("NBUF must be at least 1");
   end
   if (PG_W < 1 || PG_W >= AW - 1) begin : g_bad_pg
      $error("PG_W must leave a page and a bank field");
   end
   if (SCR_BIT >= AW) begin : g_bad_scr
      $error("SCR_BIT outside the address");
   end
   if (FAST_LAT < 1 || SLOW_LAT < FAST_LAT) begin : g_bad_lat
      $error("latencies must satisfy 1 <= FAST_LAT <= SLOW_LAT");
   end

   logic          rd_open, full, acc, look_hit, arr_vld;
   logic [AW-1:0] acc_addr, arr_addr;
   logic [DW-1:0] look_data;
   src_e          acc_src, rsp_src_e;

   assign rd_open    = !ctl_op_vld && !full;
   assign hst_rd_rdy = rd_open;
   assign ctl_rd_rdy = rd_open && !hst_rd_vld;
   assign acc        = rd_open && (hst_rd_vld || ctl_rd_vld);
   assign acc_src    = hst_rd_vld ? SRC_HOST : SRC_CTRL;
   assign acc_addr   = hst_rd_vld ? hst_rd_addr : ctl_rd_addr;
   assign mem_rd_en  = acc && !look_hit;
   assign mem_rd_addr = acc_addr;
   assign rsp_src    = rsp_src_e;

   flash_rdbuf_entries #(.AW(AW), .DW(DW), .NBUF(NBUF), .PG_W(PG_W)) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .look_addr (acc_addr),
      .look_hit  (look_hit),
      .look_data (look_data),
      .fill_vld  (arr_vld),
      .fill_addr (arr_addr),
      .fill_data (mem_rd_data),
      .op_vld    (ctl_op_vld),
      .op_kind   (opk_e'(ctl_op_kind)),
      .op_addr   (ctl_op_addr),
      .st_vld    (buf_vld),
      .st_haz    (buf_haz),
      .st_addr   (buf_addr)
   );

   flash_rdbuf_order #(.AW(AW), .DW(DW), .NTAG(NTAG),
                       .FAST_LAT(FAST_LAT), .SLOW_LAT(SLOW_LAT)) u_ord (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (acc),
      .acc_src  (acc_src),
      .acc_hit  (look_hit),
      .acc_slow (acc_addr[SCR_BIT]),
      .acc_addr (acc_addr),
      .acc_data (look_data),
      .mem_data (mem_rd_data),
      .full     (full),
      .arr_vld  (arr_vld),
      .arr_addr (arr_addr),
      .rsp_vld  (rsp_vld),
      .rsp_src  (rsp_src_e),
      .rsp_data (rsp_data)
   );

   AST_OP_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_op_vld |-> !mem_rd_en)
      else $error("memory read during a command"); // R12
   AST_CTL_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_rd_vld && ctl_rd_vld && !ctl_op_vld && !full) |=> (rsp_vld || !rsp_vld) && $past(acc_src) == SRC_HOST)
      else $error("controller won over host"); // R10

endmodule

// File: tb/sim_flash_rdbuf.sv
`timescale 1ns/1ps
module sim_flash_rdbuf;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hst_rd_vld = 1'b0, ctl_rd_vld = 1'b0, ctl_op_vld = 1'b0;
   logic [7:0]  hst_rd_addr = '0, ctl_rd_addr = '0, ctl_op_addr = '0;
   logic [1:0]  ctl_op_kind = '0;
   logic        hst_rd_rdy, ctl_rd_rdy, mem_rd_en, rsp_vld, rsp_src;
   logic [7:0]  mem_rd_addr;
   logic [15:0] mem_rd_data, rsp_data, prog_data = '0;
   logic [3:0]  buf_vld, buf_haz;
   logic [31:0] buf_addr;

   logic [15:0] mem [256];
   logic [15:0] mem_q = '0;
   int n_chk = 0, n_err = 0, cyc = 0, last_lat = 0, rlog_n = 0, stalls = 0, mrd_cnt = 0;
   int q_src[$], q_data[$], q_cyc[$];
   int rlog_src[16];
   logic [15:0] last_data = '0;
   int b_src[8], b_addr[8];

   always #2.5 clk = ~clk;

   flash_rdbuf u0 (
      .clk(clk), .rst_n(rst_n),
      .hst_rd_vld(hst_rd_vld), .hst_rd_addr(hst_rd_addr), .hst_rd_rdy(hst_rd_rdy),
      .ctl_rd_vld(ctl_rd_vld), .ctl_rd_addr(ctl_rd_addr), .ctl_rd_rdy(ctl_rd_rdy),
      .ctl_op_vld(ctl_op_vld), .ctl_op_kind(ctl_op_kind), .ctl_op_addr(ctl_op_addr),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .rsp_vld(rsp_vld), .rsp_src(rsp_src), .rsp_data(rsp_data),
      .buf_vld(buf_vld), .buf_haz(buf_haz), .buf_addr(buf_addr)
   );

   assign mem_rd_data = mem_q;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // backing memory: erase writes all ones, program writes prog_data
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         for (int a = 0; a < 256; a++) mem[a] = 16'(a * 37 + 5);
      end else begin
         if (ctl_op_vld) begin
            for (int a = 0; a < 256; a++) begin
               if (ctl_op_kind == 2'd1 && a == int'(ctl_op_addr)) mem[a] = prog_data;
               if (ctl_op_kind == 2'd2 && (a >> 3) == int'(ctl_op_addr >> 3)) mem[a] = 16'hFFFF;
               if (ctl_op_kind == 2'd3 && (a >> 7) == int'(ctl_op_addr >> 7)) mem[a] = 16'hFFFF;
            end
         end
         if (mem_rd_en) mem_q <= mem[mem_rd_addr];
      end
   end

   // scoreboard: responses must match acceptance order and memory contents
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_rd_en) mrd_cnt++;
         if (rsp_vld) begin
            if (q_src.size() == 0) begin
               check(1'b0, "R9 response with nothing pending", int'(rsp_data), 0);
            end else begin
               int s, d, c;
               s = q_src.pop_front();
               d = q_data.pop_front();
               c = q_cyc.pop_front();
               check(int'(rsp_src) == s && int'(rsp_data) == d, "R9 owner/data in order",
                     {15'd0, rsp_src, rsp_data}, (s << 16) | d);
               last_lat  = cyc - c;
               last_data = rsp_data;
               if (rlog_n < 16) begin
                  rlog_src[rlog_n] = int'(rsp_src);
                  rlog_n++;
               end
            end
         end
         if (hst_rd_vld && hst_rd_rdy) begin
            q_src.push_back(0); q_data.push_back(int'(mem[hst_rd_addr])); q_cyc.push_back(cyc);
         end else if (ctl_rd_vld && ctl_rd_rdy) begin
            q_src.push_back(1); q_data.push_back(int'(mem[ctl_rd_addr])); q_cyc.push_back(cyc);
         end
      end
   end

   task automatic do_reset();
      @(posedge clk); #1;
      rst_n = 1'b0; hst_rd_vld = 1'b0; ctl_rd_vld = 1'b0; ctl_op_vld = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      q_src.delete(); q_data.delete(); q_cyc.delete();
      rlog_n = 0;
      rst_n = 1'b1;
   endtask

   task automatic burst(input int n);
      stalls = 0;
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1;
         hst_rd_vld = (b_src[k] == 0); ctl_rd_vld = (b_src[k] == 1);
         hst_rd_addr = 8'(b_addr[k]); ctl_rd_addr = 8'(b_addr[k]);
         forever begin
            @(negedge clk);
            if (b_src[k] == 0 ? hst_rd_rdy : ctl_rd_rdy) break;
            stalls++;
         end
      end
      @(posedge clk); #1;
      hst_rd_vld = 1'b0; ctl_rd_vld = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (q_src.size() != 0);
      @(negedge clk);
   endtask

   task automatic rd1(input int src, input int addr);
      b_src[0] = src; b_addr[0] = addr;
      burst(1);
      wait_idle();
   endtask

   task automatic op(input int kind, input int addr, input int data);
      @(posedge clk); #1;
      ctl_op_vld = 1'b1; ctl_op_kind = 2'(kind); ctl_op_addr = 8'(addr); prog_data = 16'(data);
      hst_rd_vld = 1'b1; hst_rd_addr = 8'(addr);
      @(negedge clk);
      check(!hst_rd_rdy && !mem_rd_en, "R12 read blocked during command",
            {hst_rd_rdy, mem_rd_en}, 0);
      @(posedge clk); #1;
      ctl_op_vld = 1'b0; hst_rd_vld = 1'b0;
      @(negedge clk);
   endtask

   function automatic int ent(input int i);
      return int'(buf_addr[i*8 +: 8]);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      int m0;
      do_reset();
      @(negedge clk);
      check(!rsp_vld && !mem_rd_en && buf_vld == 0 && buf_haz == 0, "R1 idle outputs",
            {rsp_vld, mem_rd_en, buf_vld, buf_haz}, 0);
      check(hst_rd_rdy && ctl_rd_rdy, "R1 ports ready", {hst_rd_rdy, ctl_rd_rdy}, 3);

      // latency of misses and hits, plain and scrambled
      m0 = mrd_cnt; rd1(0, 8'h05);
      check(last_lat == 2 && mrd_cnt == m0 + 1, "R3 fast miss latency", last_lat, 2);
      check(buf_vld == 4'b0001 && ent(0) == 8'h05, "R13 entry 0 status", ent(0), 5);
      m0 = mrd_cnt; rd1(1, 8'h05);
      check(last_lat == 1 && mrd_cnt == m0, "R2 hit latency", last_lat, 1);
      rd1(0, 8'h45);
      check(last_lat == 5, "R3 slow miss latency", last_lat, 5);
      rd1(0, 8'h45);
      check(last_lat == 1, "R2 slow-region hit", last_lat, 1);
      check(buf_vld == 4'b0011 && ent(1) == 8'h45, "R4 lowest free entry", ent(1), 8'h45);

      // program eviction
      op(1, 8'h05, 16'hBEEF);
      check(buf_vld == 4'b0010 && buf_haz == 4'b0001, "R5 program evicts", {buf_vld, buf_haz}, 8'h21);
      rd1(0, 8'h05);
      check(last_lat == 2 && last_data == 16'hBEEF, "R5 reread gets programmed word", last_data, 16'hBEEF);
      check(buf_haz == 4'b0000 && buf_vld == 4'b0011, "R5 refill clears hazard", buf_haz, 0);

      // page erase
      do_reset();
      rd1(0, 8'h08); rd1(0, 8'h0C); rd1(1, 8'h10); rd1(1, 8'h45);
      op(2, 8'h0A, 0);
      check(buf_vld == 4'b1100 && buf_haz == 4'b0011, "R6 page erase evicts its page", {buf_vld, buf_haz}, 8'hC3);
      rd1(0, 8'h0C);
      check(last_lat == 2 && last_data == 16'hFFFF && ent(0) == 8'h0C, "R6 erased word reread", last_data, 16'hFFFF);

      // bank erase and ignored command
      do_reset();
      rd1(0, 8'h01); rd1(0, 8'h81); rd1(1, 8'h90); rd1(1, 8'h02);
      op(3, 8'h80, 0);
      check(buf_vld == 4'b1001 && buf_haz == 4'b0110, "R7 bank erase evicts bank", {buf_vld, buf_haz}, 8'h96);
      rd1(0, 8'h90);
      check(last_data == 16'hFFFF && buf_vld == 4'b1011, "R7 erased bank reread", last_data, 16'hFFFF);
      op(0, 8'h01, 0);
      check(buf_vld == 4'b1011 && buf_haz == 4'b0100, "R8 kind 0 ignored", {buf_vld, buf_haz}, 8'hB4);
      rd1(1, 8'h01);
      check(last_lat == 1, "R8 entry still hits", last_lat, 1);

      // round-robin replacement and duplicate suppression
      do_reset();
      rd1(0, 8'h20); rd1(0, 8'h21); rd1(0, 8'h22); rd1(0, 8'h23);
      rd1(0, 8'h24);
      check(ent(0) == 8'h24, "R4 round robin first victim", ent(0), 8'h24);
      rd1(1, 8'h25);
      check(ent(1) == 8'h25 && buf_vld == 4'b1111, "R4 round robin second victim", ent(1), 8'h25);
      do_reset();
      b_src[0] = 0; b_addr[0] = 8'h30; b_src[1] = 0; b_addr[1] = 8'h30;
      burst(2); wait_idle();
      check(buf_vld == 4'b0001, "R4 no duplicate entry", buf_vld, 1);

      // slow then fast keeps order
      do_reset();
      b_src[0] = 0; b_addr[0] = 8'h40; b_src[1] = 1; b_addr[1] = 8'h01;
      burst(2); wait_idle();
      check(rlog_n == 2 && rlog_src[0] == 0 && rlog_src[1] == 1, "R9 slow before fast", rlog_src[0], 0);
      check(last_lat == 5, "R9 fast read held behind slow", last_lat, 5);

      // arbitration
      do_reset();
      @(posedge clk); #1;
      hst_rd_vld = 1'b1; hst_rd_addr = 8'h11; ctl_rd_vld = 1'b1; ctl_rd_addr = 8'h12;
      @(negedge clk);
      check(hst_rd_rdy && !ctl_rd_rdy, "R10 host wins", {hst_rd_rdy, ctl_rd_rdy}, 2);
      @(posedge clk); #1;
      hst_rd_vld = 1'b0;
      @(negedge clk);
      check(ctl_rd_rdy, "R10 controller next", ctl_rd_rdy, 1);
      @(posedge clk); #1;
      ctl_rd_vld = 1'b0;
      wait_idle();
      check(rlog_n == 2 && rlog_src[0] == 0 && rlog_src[1] == 1, "R10 response order", rlog_src[1], 1);

      // outstanding limit
      do_reset();
      for (int k = 0; k < 5; k++) begin b_src[k] = 0; b_addr[k] = 8'h40 + k; end
      burst(5); wait_idle();
      check(stalls == 2, "R11 stall at four outstanding", stalls, 2);

      // sweep with interleaved commands
      do_reset();
      for (int i = 0; i < 256; i++) begin
         b_src[0] = i & 1;       b_addr[0] = i;
         b_src[1] = (~i) & 1;    b_addr[1] = (i * 5 + 3) & 255;
         b_src[2] = 0;           b_addr[2] = i;
         burst(3);
         if ((i % 8) == 7) op(((i % 32) == 31) ? 2 : 1, i, i * 3 + 1);
      end
      wait_idle();
      check(q_src.size() == 0, "R9 all responses returned", q_src.size(), 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule